// File: doc/BRIEF.md
# Clocked Transfer-Start / Transfer-Acknowledge Bus Slave

This block is a slave on a clocked external bus. It owns a 16-byte window of a 24-bit address space, backed by four 32-bit words of internal storage. A master opens a transaction by pulling `ts_n` low for exactly one clock. In that same cycle it presents the address, the direction, the transfer size and the burst request. The slave latches these fields on that edge and pays no further attention to them. It then waits a fixed number of cycles, set by a parameter, and pulls `ta_n` low once for each data beat.

Single transfers move a byte, a half-word or a word. Sub-word writes touch only the addressed byte lanes of the stored word. A burst moves the four words of the window. It starts at the word the master asked for (critical word first) and then wraps through the rest of the block, one beat per clock. The master keeps `bdip_n` low to ask for another beat. A request that breaks natural alignment, uses the reserved size code, or asks for a burst at a size other than word is still acknowledged, but with a single beat. That beat raises `err` and writes nothing.

Top module: `tsta_slave`

## Requirements
- R1: While `rst` is high, and afterwards until a transaction is started, `ta_n` and `bi_n` are 1, `err` is 0 and `rdata` is 0. All four storage words read back as 0 after reset.
- R2: Address, direction, size and burst request are taken only on the rising edge where `ts_n` is 0. Changes on those inputs in later cycles of the transaction have no effect on which word is accessed, on the data returned, or on what is written.
- R3: For a selected transaction whose `ts_n` cycle is cycle 0, the first `ta_n` low is in cycle 1 + WAIT_STATES. A single transfer holds `ta_n` low for exactly one cycle.
- R4: A transaction is selected only when `addr[23:4]` equals `BASE_ADDR[23:4]`. For any other address, `ta_n` stays high and storage is unchanged.
- R5: `tsize` 00 means word, 01 means byte and 10 means half-word. A write updates only the addressed byte lanes. Byte offset `addr[1:0]`=0 maps to `wdata[31:24]` and offset 3 maps to `wdata[7:0]`. A half-word at offset 0 uses bits 31:16 and at offset 2 uses bits 15:0.
- R6: During a read beat, `rdata` carries the full stored word selected by the beat's word index. In every cycle where `ta_n` is high, and on write or error beats, `rdata` is 0.
- R7: A burst is requested with `burst_n`=0 and `tsize`=00. It gives consecutive one-cycle beats. The word index starts at `addr[3:2]` and increases by one modulo 4. The burst has at most 4 beats.
- R8: After each burst beat except the fourth, the burst continues only if `bdip_n` is 0 at the end of that beat. Otherwise the burst ends after that beat.
- R9: Any of the following gives exactly one beat with `err`=1 in the same cycle as `ta_n` low, and leaves storage unchanged: a half-word with `addr[0]`=1, a word with `addr[1:0]`≠0, `tsize`=11, or a burst request with `tsize`≠00.
- R10: `bi_n` is low only on an acknowledged beat of a burst request while bursts are disabled (BURSTS_ON=0). Such a request is then served as a single transfer. With bursts enabled, `bi_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ts_n | input | 1 | Transfer start, low for the first cycle of a transaction |
| addr | input | 24 | Byte address, bit 0 is the least significant |
| rd_wr | input | 1 | 1 for read, 0 for write |
| tsize | input | 2 | Transfer size: 00 word, 01 byte, 10 half-word, 11 reserved |
| burst_n | input | 1 | Low to request a 4-word burst |
| bdip_n | input | 1 | Low to request another burst beat |
| wdata | input | 32 | Write data, byte offset 0 on bits 31:24 |
| rdata | output | 32 | Read data, valid while `ta_n` is low on a read |
| ta_n | output | 1 | Transfer acknowledge, low once per beat |
| bi_n | output | 1 | Burst inhibit, low when a burst is refused |
| err | output | 1 | High with the acknowledge of a rejected request |

## Verification
The main path is tried with random mixes of reads and writes at all three sizes and every byte offset, against a reference copy of the four words. Lane placement is separated from whole-word handling by reading back after sub-word writes. Bursts start from each of the four word indices and are stopped after one to four beats, which separates correct wrap order from linear order and shows that early termination is honoured. After every `ts_n` cycle the address, direction, size and burst lines are scrambled, so any design that samples them later than the start cycle is exposed. Out-of-window addresses, misaligned sizes, the reserved size and bursts at sub-word size tell a silent no-response apart from an error beat.

// File: rtl/tsta_pkg.sv
package tsta_pkg;

    localparam int unsigned BLK_WORDS = 4;
    localparam int unsigned IDX_W     = $clog2(BLK_WORDS);
    localparam int unsigned LANES     = 4;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_BEAT = 2'b10
    } phase_e;

    // Request fields latched at transfer start
    typedef struct packed {
        logic             write;
        logic             burst;
        logic             fault;
        logic             refuse;
        logic [IDX_W-1:0] widx;
        logic [LANES-1:0] lanes;
    } xreq_t;

    // Natural alignment rule per size
    function automatic logic size_ok(size_e sz, logic [1:0] off);
        case (sz)
            SZ_BYTE: size_ok = 1'b1;
            SZ_HALF: size_ok = (off[0] == 1'b0);
            SZ_WORD: size_ok = (off == 2'b00);
            default: size_ok = 1'b0;
        endcase
    endfunction

    // Byte lanes; lane 3 (bits 31:24) is byte offset 0
    function automatic logic [LANES-1:0] lane_mask(size_e sz, logic [1:0] off);
        case (sz)
            SZ_BYTE: lane_mask = 4'b1000 >> off;
            SZ_HALF: lane_mask = off[1] ? 4'b0011 : 4'b1100;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/tsta_decode.sv
module tsta_decode
    import tsta_pkg::*;
#(
    parameter int unsigned AW        = 24,
    parameter logic [AW-1:0] BASE_ADDR = 24'h001230,
    parameter bit          BURSTS_ON = 1'b1
) (
    input  logic [AW-1:0] addr,
    input  logic          rd_wr,
    input  logic [1:0]    tsize,
    input  logic          burst_n,
    output logic          hit,
    output xreq_t         req
);
    localparam int unsigned BLK_LSB = 4;

    size_e sz;
    logic  want_burst;
    logic  bad;

    always_comb begin
        sz         = size_e'(tsize);
        hit        = (addr[AW-1:BLK_LSB] == BASE_ADDR[AW-1:BLK_LSB]);
        want_burst = !burst_n && BURSTS_ON;
        bad        = !size_ok(sz, addr[1:0]) || (want_burst && sz != SZ_WORD);
        req.write  = !rd_wr;
        req.fault  = bad;
        req.burst  = want_burst && !bad;
        req.refuse = !burst_n && !BURSTS_ON;
        req.widx   = addr[IDX_W+1:2];
        req.lanes  = want_burst ? {LANES{1'b1}} : lane_mask(sz, addr[1:0]);
    end
endmodule

// File: rtl/tsta_ctrl.sv
module tsta_ctrl
    import tsta_pkg::*;
#(
    parameter int unsigned WAIT_STATES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ts_n,
    input  logic             hit,
    input  xreq_t            req,
    input  logic             bdip_n,
    output logic             ack,
    output xreq_t            cur,
    output logic [IDX_W-1:0] idx
);
    localparam int unsigned WCW = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
    localparam int unsigned BCW = $clog2(BLK_WORDS);

    phase_e         phase;
    logic [WCW-1:0] wcnt;
    logic [BCW-1:0] beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= ST_IDLE;
            wcnt  <= '0;
            beat  <= '0;
            idx   <= '0;
            cur   <= '0;
        end else begin
            case (phase)
                ST_IDLE: begin
                    if (!ts_n && hit) begin
                        cur  <= req;
                        idx  <= req.widx;
                        beat <= '0;
                        wcnt <= '0;
                        phase <= (WAIT_STATES == 0) ? ST_BEAT : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wcnt == WCW'(WAIT_STATES - 1)) begin
                        phase <= ST_BEAT;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_BEAT: begin
                    if (cur.burst && beat != BCW'(BLK_WORDS - 1) && !bdip_n) begin
                        beat <= beat + 1'b1;
                        idx  <= idx + 1'b1;
                    end else begin
                        phase <= ST_IDLE;
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    assign ack = (phase == ST_BEAT);
endmodule

// File: rtl/tsta_store.sv
module tsta_store
    import tsta_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [LANES-1:0] lanes,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rword
);
    localparam int unsigned LW = DW / LANES;

    logic [DW-1:0] words [BLK_WORDS];

    for (genvar w = 0; w < BLK_WORDS; w++) begin : g_word
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    words[w][l*LW +: LW] <= '0;
                end else if (we && idx == IDX_W'(w) && lanes[l]) begin
                    words[w][l*LW +: LW] <= wdata[l*LW +: LW];
                end
            end
        end
    end

    assign rword = words[idx];
endmodule

// File: rtl/tsta_slave.sv
module tsta_slave
    import tsta_pkg::*;
#(
    parameter int unsigned   AW          = 24,
    parameter int unsigned   DW          = 32,
    parameter logic [AW-1:0] BASE_ADDR   = 24'h001230,
    parameter int unsigned   WAIT_STATES = 2,
    parameter bit            BURSTS_ON   = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ts_n,
    input  logic [AW-1:0] addr,
    input  logic          rd_wr,
    input  logic [1:0]    tsize,
    input  logic          burst_n,
    input  logic          bdip_n,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ta_n,
    output logic          bi_n,
    output logic          err
);
    logic             hit;
    xreq_t            dreq;
    xreq_t            cur;
    logic             ack;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    rword;
    logic             we;

    tsta_decode #(.AW(AW), .BASE_ADDR(BASE_ADDR), .BURSTS_ON(BURSTS_ON)) u_dec (
        .addr(addr), .rd_wr(rd_wr), .tsize(tsize), .burst_n(burst_n),
        .hit(hit), .req(dreq)
    );

    tsta_ctrl #(.WAIT_STATES(WAIT_STATES)) u_ctrl (
        .clk(clk), .rst(rst), .ts_n(ts_n), .hit(hit), .req(dreq),
        .bdip_n(bdip_n), .ack(ack), .cur(cur), .idx(idx)
    );

    assign we = ack && cur.write && !cur.fault;

    tsta_store #(.DW(DW)) u_store (
        .clk(clk), .rst(rst), .we(we), .idx(idx), .lanes(cur.lanes),
        .wdata(wdata), .rword(rword)
    );

    assign ta_n  = !ack;
    assign err   = ack && cur.fault;
    assign bi_n  = !(ack && cur.refuse);
    assign rdata = (ack && !cur.write && !cur.fault) ? rword : '0;
endmodule

// File: rtl/tsta_slave_chk.sv
module tsta_slave_chk #(
    parameter int unsigned DW          = 32,
    parameter int unsigned WAIT_STATES = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          ts_n,
    input logic          ta_n,
    input logic          bi_n,
    input logic          err,
    input logic [DW-1:0] rdata
);
    logic [3:0] since_ts;
    logic [2:0] ta_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_ts <= '0;
            ta_run   <= '0;
        end else begin
            if (!ts_n) since_ts <= 4'd1;
            else if (since_ts != 4'hF) since_ts <= since_ts + 4'd1;
            if (!ta_n) ta_run <= (ta_run == 3'd7) ? ta_run : ta_run + 3'd1;
            else ta_run <= '0;
        end
    end

    AST_FIRST_TA_DELAY: assert property (@(posedge clk) disable iff (rst)
        $fell(ta_n) |-> since_ts == 4'(WAIT_STATES + 1)); // R3
    AST_BURST_MAX_BEATS: assert property (@(posedge clk) disable iff (rst)
        !ta_n |-> ta_run < 3'd4); // R7
    AST_ERR_WITH_TA: assert property (@(posedge clk) disable iff (rst)
        err |-> !ta_n); // R9
    AST_ERR_ONE_BEAT: assert property (@(posedge clk) disable iff (rst)
        err |=> ta_n); // R9
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        ta_n |-> rdata == '0); // R6
    AST_BI_ONLY_ON_TA: assert property (@(posedge clk) disable iff (rst)
        !bi_n |-> !ta_n); // R10
endmodule

bind tsta_slave tsta_slave_chk #(.DW(DW), .WAIT_STATES(WAIT_STATES)) u_chk (
    .clk(clk), .rst(rst), .ts_n(ts_n), .ta_n(ta_n), .bi_n(bi_n),
    .err(err), .rdata(rdata)
);

// File: tb/tsta_slave_tb.sv
`timescale 1ns/1ps
module tsta_slave_tb;
    localparam int unsigned    WS   = 2;
    localparam logic [23:0]    BASE = 24'hA51230;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ts_n = 1'b1;
    logic [23:0] addr = '0;
    logic        rd_wr = 1'b1;
    logic [1:0]  tsize = 2'b00;
    logic        burst_n = 1'b1;
    logic        bdip_n = 1'b1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ta_n, bi_n, err;

    int nchk = 0;
    int nfail = 0;
    logic [31:0] model [4];

    always #10 clk = ~clk;

    tsta_slave #(.BASE_ADDR(BASE), .WAIT_STATES(WS)) u_dut (
        .clk(clk), .rst(rst), .ts_n(ts_n), .addr(addr), .rd_wr(rd_wr),
        .tsize(tsize), .burst_n(burst_n), .bdip_n(bdip_n), .wdata(wdata),
        .rdata(rdata), .ta_n(ta_n), .bi_n(bi_n), .err(err)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_lanes(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'b01) return 4'b1000 >> off;
        if (sz == 2'b10) return off[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic exp_aligned(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'b01) return 1'b1;
        if (sz == 2'b10) return !off[0];
        if (sz == 2'b00) return off == 2'b00;
        return 1'b0;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] ln);
        logic [31:0] r = old;
        for (int j = 0; j < 4; j++) if (ln[j]) r[8*j +: 8] = nw[8*j +: 8];
        return r;
    endfunction

    // One transaction; nc = requested burst beats (1..4)
    task automatic xfer(input logic [23:0] a, input logic rd, input logic [1:0] sz,
                        input logic bst, input int nc, input logic [31:0] seed);
        logic hit, fault, isb;
        int   nb;
        string tag;
        hit   = (a[23:4] == BASE[23:4]);
        fault = !exp_aligned(sz, a[1:0]) || (bst && sz != 2'b00);
        isb   = bst && !fault;
        nb    = !hit ? 0 : (fault ? 1 : (isb ? nc : 1));
        tag   = !hit ? "R4" : (fault ? "R9" : (isb ? (nc < 4 ? "R8" : "R7") : "R2/R3"));
        @(negedge clk);
        ts_n = 1'b0; addr = a; rd_wr = rd; tsize = sz; burst_n = !bst;
        wdata = seed; bdip_n = 1'b1;
        for (int k = 1; k <= WS + 6; k++) begin
            int i;
            logic inb;
            logic [1:0] w;
            logic [31:0] wd;
            @(negedge clk);
            if (k == 1) begin
                // R2: scramble sampled fields after the start cycle
                ts_n = 1'b1; addr = $urandom; rd_wr = $urandom; tsize = $urandom;
                burst_n = $urandom;
            end
            i   = k - WS - 1;
            inb = (i >= 0) && (i < nb);
            w   = 2'(a[3:2] + i);
            wd  = seed + 32'(i) * 32'h01010101;
            chk(ta_n == !inb, {tag, " ta_n"}, {31'd0, ta_n}, {31'd0, !inb});
            chk(err == (inb && fault), "R9 err", {31'd0, err}, {31'd0, inb && fault});
            chk(rdata == ((inb && rd && !fault) ? model[w] : 32'd0), {tag, " R6 rdata"},
                rdata, (inb && rd && !fault) ? model[w] : 32'd0);
            chk(bi_n == 1'b1, "R10 bi_n", {31'd0, bi_n}, 32'd1);
            if (inb) begin
                wdata  = wd;
                bdip_n = !(isb && i < nb - 1);
                if (!rd && !fault)
                    model[w] = merge(model[w], wd, isb ? 4'hF : exp_lanes(sz, a[1:0]));
            end else begin
                bdip_n = 1'b1;
            end
        end
    endtask

    initial begin
        for (int j = 0; j < 4; j++) model[j] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk(ta_n == 1'b1 && bi_n == 1'b1 && err == 1'b0, "R1 ctl", {29'd0, ta_n, bi_n, err}, 32'd6);
        chk(rdata == 32'd0, "R1 rdata", rdata, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(ta_n == 1'b1 && err == 1'b0, "R1 idle", {30'd0, ta_n, err}, 32'd2);
        // R1: storage cleared
        for (int j = 0; j < 4; j++) xfer(BASE + 24'(4*j), 1'b1, 2'b00, 1'b0, 1, '0);
        // R7: full wrapping burst from critical word 2, then read back from 3
        xfer(BASE + 24'h8, 1'b0, 2'b00, 1'b1, 4, 32'h11223344);
        xfer(BASE + 24'hC, 1'b1, 2'b00, 1'b1, 4, '0);
        // R8: burst stopped after two beats, then after one
        xfer(BASE + 24'h4, 1'b0, 2'b00, 1'b1, 2, 32'hA0B0C0D0);
        xfer(BASE + 24'h0, 1'b1, 2'b00, 1'b1, 1, '0);
        // R5: byte lanes at each offset, half-words, then whole-word reads
        for (int j = 0; j < 4; j++) xfer(BASE + 24'(j), 1'b0, 2'b01, 1'b0, 1, 32'hF1E2D3C4 + 32'(j));
        xfer(BASE + 24'h6, 1'b0, 2'b10, 1'b0, 1, 32'h5A5AA5A5);
        xfer(BASE + 24'h4, 1'b1, 2'b00, 1'b0, 1, '0);
        xfer(BASE + 24'h0, 1'b1, 2'b00, 1'b0, 1, '0);
        // R9: misaligned half, misaligned word, reserved size, burst at byte size
        xfer(BASE + 24'h5, 1'b0, 2'b10, 1'b0, 1, 32'hDEADBEEF);
        xfer(BASE + 24'h6, 1'b0, 2'b00, 1'b0, 1, 32'hDEADBEEF);
        xfer(BASE + 24'h8, 1'b0, 2'b11, 1'b0, 1, 32'hDEADBEEF);
        xfer(BASE + 24'h8, 1'b0, 2'b01, 1'b1, 4, 32'hDEADBEEF);
        xfer(BASE + 24'h4, 1'b1, 2'b00, 1'b0, 1, '0);
        // R4: outside the window
        xfer(BASE + 24'h10, 1'b0, 2'b00, 1'b0, 1, 32'hCAFEF00D);
        xfer(BASE ^ 24'h800000, 1'b1, 2'b00, 1'b1, 4, '0);
        // Random mix
        void'($urandom(32'd4242));
        for (int n = 0; n < 400; n++) begin
            logic [23:0] a;
            logic bst;
            a   = ($urandom % 8 == 0) ? 24'($urandom) : {BASE[23:4], 4'($urandom)};
            bst = ($urandom % 4 == 0);
            xfer(a, 1'($urandom), bst && ($urandom % 4 != 0) ? 2'b00 : 2'($urandom),
                 bst, 1 + int'($urandom % 4), $urandom);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        nfail++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule